// File: doc/BRIEF.md
# Banked Gamma Lookup Pixel Corrector

This block is a gamma correction stage in a display pipeline. A pixel carrying three 10-bit colour components arrives on a valid/ready input stream. Each component indexes its own colour column of a programmable lookup table, and the three looked-up values leave together on a valid/ready output stream two register stages later. A pixel position counter, loaded from a frame size register, marks the last pixel of each line and the last pixel of each frame on the output.

Software fills the table through a write-only register port. It selects one bank at a time and then writes entries through one or two address windows. Entries are 10 or 12 bits wide, chosen at run time. In 10-bit format all three colours are packed in one word. In 12-bit format red and green go through the primary window and blue goes through the secondary window. When differential storage is enabled, every odd entry holds a signed step from the even entry just below it, and the block rebuilds the absolute value on the read path. The block passes pixels through unchanged unless it is enabled, relay is off and the table is switched on.

Top module: `gamma_lut_corrector`

## Requirements
- R1: After synchronous reset the output valid is low, the input is ready, and enable, relay, table-on, 12-bit format, bank and both frame sizes are all zero.
- R2: Bit 0 of the register at byte offset 0x000 enables the block. While it is 0, each output component equals the matching input component, zero-extended to 12 bits.
- R3: In the register at 0x020, bit 0 selects relay (pass-through) and bit 1 switches the table on. A pixel is looked up only if enable=1, relay=0 and table-on=1; otherwise it passes through as in R2.
- R4: In the register at 0x100, bits 1:0 select the bank and bit 2 selects 12-bit format. A window write at slot i reaches table entry bank*BANK_DEPTH + i.
- R5: Slot i of the primary window is byte offset 0x700 + 4*i, and slot i of the secondary window is 0xB00 + 4*i. The secondary window decodes only in 12-bit format, and it then takes priority over the primary window.
- R6: In 10-bit format a primary word carries red in bits 29:20, green in bits 19:10 and blue in bits 9:0.
- R7: In 12-bit format a primary word carries red in bits 11:0 and green in bits 23:12. A secondary word carries blue in bits 11:0.
- R8: Input data holds red in bits 29:20, green in bits 19:10 and blue in bits 9:0. Output data holds red in bits 35:24, green in bits 23:12 and blue in bits 11:0. The table index is the upper bits of the component (the whole component in the default 1024-entry configuration). The output of an even entry is its value masked to the current format width.
- R9: With differential storage on, an odd entry is the even entry below it plus the odd entry read as a two's complement number of the current format width. The sum is clamped to the range 0 to 2^width-1.
- R10: Pixels leave in the order they arrived. Without backpressure, a pixel taken at one clock edge is valid at the output after the second following edge. While the output is valid and not ready, its data and flags hold.
- R11: The register at 0x030 holds the line length in bits 28:16 and the line count in bits 12:0, and writing it restarts the position counter. End-of-line marks the pixel that completes a line. End-of-frame marks the last line's end-of-line pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_ready | output | 1 | Input pixel accepted when high with valid |
| pix_in_data | input | 30 | Input pixel {R,G,B}, 10 bits each |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_ready | input | 1 | Downstream ready |
| pix_out_data | output | 36 | Output pixel {R,G,B}, 12 bits each |
| pix_out_eol | output | 1 | Last pixel of a line |
| pix_out_eof | output | 1 | Last pixel of a frame |

## Verification
The assertions check on every cycle that a stalled output holds its data and flags, that valid falls after reset, that end-of-frame never appears without end-of-line, and that the line and row positions stay inside the programmed frame size. Correct table values can only be shown by the bench scenarios. These include delta reconstruction with clamping at both ends, bank and window addressing in both entry formats, the three pass-through conditions and flag placement for a small frame. The bench compares every output pixel against a behavioural model under random backpressure.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_R = 0;
  localparam int CH_G = 1;
  localparam int CH_B = 2;
  localparam int ENT_W = 12;
  localparam int SIZE_W = 13;

  localparam logic [11:0] OFS_ENABLE  = 12'h000;
  localparam logic [11:0] OFS_CONFIG  = 12'h020;
  localparam logic [11:0] OFS_SIZE    = 12'h030;
  localparam logic [11:0] OFS_BANK    = 12'h100;
  localparam logic [11:0] OFS_WIN_PRI = 12'h700;
  localparam logic [11:0] OFS_WIN_SEC = 12'hB00;

  typedef struct packed {
    logic enable;
    logic relay;
    logic lut_on;
    logic wide;
  } gamma_mode_t;

  // Rebuild one table value from an even/odd pair read in the same cycle.
  function automatic logic [ENT_W-1:0] gamma_rebuild(
    input logic [ENT_W-1:0] ev,
    input logic [ENT_W-1:0] od,
    input logic             odd,
    input logic             wide,
    input logic             diff
  );
    logic [ENT_W-1:0] lim;
    logic signed [ENT_W+1:0] base, step, sum;
    lim  = wide ? 12'hFFF : 12'h3FF;
    base = $signed({2'b00, ev & lim});
    step = wide ? $signed({{2{od[11]}}, od}) : $signed({{4{od[9]}}, od[9:0]});
    sum  = base + step;
    if (!odd) return ev & lim;
    if (!diff) return od & lim;
    if (sum < 0) return '0;
    if (sum > $signed({2'b00, lim})) return lim;
    return sum[ENT_W-1:0];
  endfunction
endpackage

// File: rtl/gamma_lut_ram.sv
module gamma_lut_ram #(
  parameter int AW = 9,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/gamma_regs.sv
module gamma_regs
  import gamma_pkg::*;
#(
  parameter int BANKS      = 4,
  parameter int BANK_DEPTH = 256,
  parameter int IDX_W      = 10,
  parameter int BANK_W     = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [11:0]                   addr,
  input  logic [31:0]                   wdata,
  output gamma_mode_t                   mode,
  output logic [SIZE_W-1:0]             hsize,
  output logic [SIZE_W-1:0]             vsize,
  output logic                          size_wr,
  output logic [NUM_CH-1:0]             lut_we,
  output logic [IDX_W-1:0]              lut_idx,
  output logic [NUM_CH-1:0][ENT_W-1:0]  lut_val
);
  localparam int WIN_BYTES = 4 * BANK_DEPTH;
  localparam int OFS_W     = $clog2(BANK_DEPTH);

  logic [BANK_W-1:0] bank_q;
  logic [12:0]       a13, rel_pri, rel_sec;
  logic              hit_pri, hit_sec;
  logic [OFS_W-1:0]  slot;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[31:30];
  assign a13     = {1'b0, addr};
  assign rel_pri = a13 - {1'b0, OFS_WIN_PRI};
  assign rel_sec = a13 - {1'b0, OFS_WIN_SEC};
  // Secondary window exists only in 12-bit format and outranks the primary one.
  assign hit_sec = wr_en && mode.wide && (a13 >= {1'b0, OFS_WIN_SEC}) && (rel_sec < 13'(WIN_BYTES));
  assign hit_pri = wr_en && !hit_sec && (a13 >= {1'b0, OFS_WIN_PRI}) && (rel_pri < 13'(WIN_BYTES));
  assign slot    = hit_sec ? rel_sec[OFS_W+1:2] : rel_pri[OFS_W+1:2];
  assign size_wr = wr_en && (addr == OFS_SIZE);

  if (BANKS > 1) begin : g_banked
    assign lut_idx = {bank_q, slot};
  end else begin : g_flat
    logic unused_bank;
    assign unused_bank = ^bank_q;
    assign lut_idx = slot;
  end

  always_comb begin
    lut_we  = '0;
    lut_val = '0;
    if (hit_sec) begin
      lut_we[CH_B]  = 1'b1;
      lut_val[CH_B] = wdata[11:0];
    end else if (hit_pri) begin
      if (mode.wide) begin
        lut_we[CH_R]  = 1'b1;
        lut_we[CH_G]  = 1'b1;
        lut_val[CH_R] = wdata[11:0];
        lut_val[CH_G] = wdata[23:12];
      end else begin
        lut_we        = '1;
        lut_val[CH_R] = {2'b00, wdata[29:20]};
        lut_val[CH_G] = {2'b00, wdata[19:10]};
        lut_val[CH_B] = {2'b00, wdata[9:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= '0;
      bank_q <= '0;
      hsize  <= '0;
      vsize  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_ENABLE: mode.enable <= wdata[0];
        OFS_CONFIG: begin
          mode.relay  <= wdata[0];
          mode.lut_on <= wdata[1];
        end
        OFS_SIZE: begin
          hsize <= wdata[28:16];
          vsize <= wdata[12:0];
        end
        OFS_BANK: begin
          bank_q    <= wdata[BANK_W-1:0];
          mode.wide <= wdata[2];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gamma_frame_pos.sv
module gamma_frame_pos #(
  parameter int SZ_W = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            step,
  input  logic [SZ_W-1:0] hsize,
  input  logic [SZ_W-1:0] vsize,
  output logic            eol,
  output logic            eof
);
  logic [SZ_W-1:0] x_q, y_q;

  assign eol = ({1'b0, x_q} + (SZ_W+1)'(1)) >= {1'b0, hsize};
  assign eof = eol && (({1'b0, y_q} + (SZ_W+1)'(1)) >= {1'b0, vsize});

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step) begin
      if (eol) begin
        x_q <= '0;
        y_q <= eof ? '0 : y_q + SZ_W'(1);
      end else begin
        x_q <= x_q + SZ_W'(1);
      end
    end
  end

  // R11: position never leaves the programmed frame
  a_r11_col_bound: assert property (@(posedge clk) disable iff (rst)
    (hsize != '0) |-> (x_q < hsize));
  a_r11_row_bound: assert property (@(posedge clk) disable iff (rst)
    (vsize != '0) |-> (y_q < vsize));
endmodule

// File: rtl/gamma_lut_corrector.sv
module gamma_lut_corrector
  import gamma_pkg::*;
#(
  parameter int COMP_W     = 10,
  parameter int BANKS      = 4,
  parameter int BANK_DEPTH = 256,
  parameter bit DIFF_EN    = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr_en,
  input  logic [11:0]              reg_addr,
  input  logic [31:0]              reg_wdata,
  input  logic                     pix_in_valid,
  output logic                     pix_in_ready,
  input  logic [3*COMP_W-1:0]      pix_in_data,
  output logic                     pix_out_valid,
  input  logic                     pix_out_ready,
  output logic [3*ENT_W-1:0]       pix_out_data,
  output logic                     pix_out_eol,
  output logic                     pix_out_eof
);
  localparam int IDX_W  = $clog2(BANKS * BANK_DEPTH);
  localparam int PAIR_W = IDX_W - 1;
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  gamma_mode_t                  mode;
  logic [SIZE_W-1:0]            hsize, vsize;
  logic                         size_wr;
  logic [NUM_CH-1:0]            lut_we;
  logic [IDX_W-1:0]             lut_idx;
  logic [NUM_CH-1:0][ENT_W-1:0] lut_val;
  logic                         adv, take, byp, eol, eof;
  logic                         v1, byp1, wide1, eol1, eof1;
  logic [NUM_CH-1:0][ENT_W-1:0] nxt;

  // Single stall signal for both stages: everything holds while output is blocked.
  assign adv          = !(pix_out_valid && !pix_out_ready);
  assign pix_in_ready = adv;
  assign take         = pix_in_valid && adv;
  assign byp          = !mode.enable || mode.relay || !mode.lut_on;

  gamma_regs #(
    .BANKS(BANKS), .BANK_DEPTH(BANK_DEPTH), .IDX_W(IDX_W), .BANK_W(BANK_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .mode(mode), .hsize(hsize), .vsize(vsize), .size_wr(size_wr),
    .lut_we(lut_we), .lut_idx(lut_idx), .lut_val(lut_val)
  );

  gamma_frame_pos #(.SZ_W(SIZE_W)) u_pos (
    .clk(clk), .rst(rst), .restart(size_wr), .step(take),
    .hsize(hsize), .vsize(vsize), .eol(eol), .eof(eof)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [COMP_W-1:0] comp, raw_q;
    logic [IDX_W-1:0]  ridx;
    logic [ENT_W-1:0]  ev_q, od_q;
    logic              odd_q;

    assign comp = pix_in_data[(NUM_CH-1-c)*COMP_W +: COMP_W];
    assign ridx = comp[COMP_W-1 -: IDX_W];

    // Even and odd entries live in separate RAMs so a pair is read in one cycle.
    gamma_lut_ram #(.AW(PAIR_W), .DW(ENT_W)) u_even (
      .clk(clk), .we(lut_we[c] && !lut_idx[0]), .waddr(lut_idx[IDX_W-1:1]),
      .wdata(lut_val[c]), .re(adv), .raddr(ridx[IDX_W-1:1]), .rdata(ev_q)
    );
    gamma_lut_ram #(.AW(PAIR_W), .DW(ENT_W)) u_odd (
      .clk(clk), .we(lut_we[c] && lut_idx[0]), .waddr(lut_idx[IDX_W-1:1]),
      .wdata(lut_val[c]), .re(adv), .raddr(ridx[IDX_W-1:1]), .rdata(od_q)
    );

    always_ff @(posedge clk) begin
      if (take) begin
        raw_q <= comp;
        odd_q <= ridx[0];
      end
    end

    assign nxt[c] = byp1 ? ENT_W'(raw_q)
                         : gamma_rebuild(ev_q, od_q, odd_q, wide1, DIFF_EN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1            <= 1'b0;
      pix_out_valid <= 1'b0;
    end else if (adv) begin
      v1            <= take;
      pix_out_valid <= v1;
    end
    if (take) begin
      byp1  <= byp;
      wide1 <= mode.wide;
      eol1  <= eol;
      eof1  <= eof;
    end
    if (adv && v1) begin
      for (int c = 0; c < NUM_CH; c++)
        pix_out_data[(NUM_CH-1-c)*ENT_W +: ENT_W] <= nxt[c];
      pix_out_eol <= eol1;
      pix_out_eof <= eof1;
    end
  end

  // R10: a blocked output keeps its contents
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (pix_out_valid && !pix_out_ready) |=>
      (pix_out_valid && $stable(pix_out_data) && $stable(pix_out_eol) && $stable(pix_out_eof)));
  // R1: reset empties the pipeline
  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> !pix_out_valid);
  // R11: frame end is always also a line end
  a_r11_eof_has_eol: assert property (@(posedge clk) disable iff (rst)
    (pix_out_valid && pix_out_eof) |-> pix_out_eol);
endmodule

// File: tb/gamma_lut_corrector_tb_top.sv
module gamma_lut_corrector_tb_top;
  localparam int NENT  = 1024;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        pix_in_valid = 1'b0;
  logic        pix_in_ready;
  logic [29:0] pix_in_data = '0;
  logic        pix_out_valid;
  logic        pix_out_ready = 1'b1;
  logic [35:0] pix_out_data;
  logic        pix_out_eol, pix_out_eof;

  always #2 clk = ~clk;

  gamma_lut_corrector dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pix_in_valid(pix_in_valid), .pix_in_ready(pix_in_ready), .pix_in_data(pix_in_data),
    .pix_out_valid(pix_out_valid), .pix_out_ready(pix_out_ready), .pix_out_data(pix_out_data),
    .pix_out_eol(pix_out_eol), .pix_out_eof(pix_out_eof)
  );

  int n_chk = 0;
  int n_bad = 0;
  int tab [3][NENT];
  bit m_en, m_relay, m_lut, m_wide;
  int hs, vs, px, py;
  logic [35:0] exp_q[$];
  bit eol_q[$], eof_q[$];
  string tag_q[$];
  string cur_tag = "R1 R2";
  bit rnd_ready = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int map_comp(int c, int v);
    int lim, ev, od, d, s;
    if (!m_en || m_relay || !m_lut) return v;
    lim = m_wide ? 4095 : 1023;
    if (v % 2 == 0) return tab[c][v] & lim;
    ev = tab[c][v-1] & lim;
    od = tab[c][v] & lim;
    d  = (od > lim / 2) ? od - (lim + 1) : od;
    s  = ev + d;
    if (s < 0) s = 0;
    if (s > lim) s = lim;
    return s;
  endfunction

  // Reference model and comparison, evaluated every cycle away from the edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (pix_in_valid && pix_in_ready) begin
        logic [35:0] ex;
        bit el, ef;
        ex[35:24] = 12'(map_comp(0, int'(pix_in_data[29:20])));
        ex[23:12] = 12'(map_comp(1, int'(pix_in_data[19:10])));
        ex[11:0]  = 12'(map_comp(2, int'(pix_in_data[9:0])));
        el = (px + 1 >= hs);
        ef = el && (py + 1 >= vs);
        if (el) begin px = 0; py = ef ? 0 : py + 1; end
        else px++;
        exp_q.push_back(ex); eol_q.push_back(el); eof_q.push_back(ef); tag_q.push_back(cur_tag);
      end
      if (pix_out_valid && pix_out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected output", 64'(pix_out_data), 0);
        else begin
          logic [35:0] ex;
          bit el, ef;
          string tg;
          ex = exp_q.pop_front(); el = eol_q.pop_front(); ef = eof_q.pop_front(); tg = tag_q.pop_front();
          chk(pix_out_data == ex, tg, 64'(pix_out_data), 64'(ex));
          chk({pix_out_eol, pix_out_eof} == {el, ef}, "R11 flags", 64'({pix_out_eol, pix_out_eof}), 64'({el, ef}));
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    pix_out_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    case (a)
      12'h000: m_en = d[0];
      12'h020: begin m_relay = d[0]; m_lut = d[1]; end
      12'h030: begin hs = int'(d[28:16]); vs = int'(d[12:0]); px = 0; py = 0; end
      12'h100: m_wide = d[2];
      default: ;
    endcase
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  function automatic int gen_val(int c, int e, int lim);
    if (e % 2 == 0) return (e * 5 + c * 311 + 17) % (lim + 1);
    case (e % 8)
      1: return (lim + 1) / 2;            // most negative step
      3: return lim / 2;                  // most positive step
      5: return 9;
      default: return (lim + 1) - 6;      // step of -6
    endcase
  endfunction

  task automatic load_wide();
    for (int b = 0; b < 4; b++) begin
      wr(12'h100, 32'(4 + b));
      for (int i = 0; i < DEPTH; i++) begin
        int e;
        e = b * DEPTH + i;
        for (int c = 0; c < 3; c++) tab[c][e] = gen_val(c, e, 4095);
        wr(12'h700 + 12'(4 * i), {8'h00, 12'(tab[1][e]), 12'(tab[0][e])});
        wr(12'hB00 + 12'(4 * i), {20'h0, 12'(tab[2][e])});
      end
    end
  endtask

  task automatic load_narrow();
    for (int b = 0; b < 4; b++) begin
      wr(12'h100, 32'(b));
      for (int i = 0; i < DEPTH; i++) begin
        int e;
        e = b * DEPTH + i;
        for (int c = 0; c < 3; c++) tab[c][e] = gen_val(c, e, 1023);
        wr(12'h700 + 12'(4 * i), {2'b00, 10'(tab[0][e]), 10'(tab[1][e]), 10'(tab[2][e])});
      end
    end
  endtask

  task automatic send(input logic [29:0] v);
    bit ok;
    pix_in_valid = 1'b1; pix_in_data = v;
    do begin
      @(negedge clk); ok = pix_in_ready;
      @(posedge clk); #1;
    end while (!ok);
    pix_in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk); #1;
  endtask

  task automatic sweep();
    for (int k = 0; k < NENT; k++)
      send({10'(k), 10'(1023 - k), 10'((k * 37) % 1024)});
  endtask

  task automatic random_px(input int n);
    for (int k = 0; k < n; k++) begin
      send(30'($urandom));
      repeat ($urandom % 2) begin @(posedge clk); #1; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: empty pipeline, ready input after reset
    chk(pix_out_valid == 1'b0, "R1 valid after reset", 64'(pix_out_valid), 0);
    chk(pix_in_ready == 1'b1, "R1 ready after reset", 64'(pix_in_ready), 1);
    @(posedge clk); #1;
    // R1 R2: default controls pass pixels through
    cur_tag = "R1 R2 reset pass-through";
    random_px(8);
    drain();

    wr(12'h030, {3'b0, 13'd8, 3'b0, 13'd4});
    load_wide();

    cur_tag = "R2 disabled pass-through";
    wr(12'h020, 32'h2);
    random_px(24);
    drain();

    wr(12'h000, 32'h1);
    cur_tag = "R3 relay pass-through";
    wr(12'h020, 32'h3);
    random_px(24);
    drain();
    cur_tag = "R3 table-off pass-through";
    wr(12'h020, 32'h0);
    random_px(24);
    drain();

    wr(12'h020, 32'h2);
    cur_tag = "R4 R5 R7 R8 R9 12-bit sweep";
    rnd_ready = 1'b1;
    sweep();
    drain();
    cur_tag = "R9 R10 random backpressure";
    random_px(200);
    drain();
    rnd_ready = 1'b0;
    drain();

    // R10: latency of two edges without backpressure
    cur_tag = "R10 latency";
    pix_in_valid = 1'b1; pix_in_data = 30'h2AB_CDE;
    @(negedge clk);
    chk(pix_in_ready == 1'b1, "R10 ready when idle", 64'(pix_in_ready), 1);
    @(posedge clk); #1;
    pix_in_valid = 1'b0;
    @(negedge clk);
    chk(pix_out_valid == 1'b0, "R10 not yet valid", 64'(pix_out_valid), 0);
    @(negedge clk);
    chk(pix_out_valid == 1'b1, "R10 valid after two edges", 64'(pix_out_valid), 1);
    @(posedge clk); #1;
    drain();

    load_narrow();
    cur_tag = "R4 R6 R8 R9 10-bit sweep";
    rnd_ready = 1'b1;
    sweep();
    drain();
    rnd_ready = 1'b0;

    // R11: small frame, flags placed on line and frame ends
    wr(12'h030, {3'b0, 13'd3, 3'b0, 13'd2});
    cur_tag = "R11 small frame data";
    random_px(13);
    drain();
    chk(exp_q.size() == 0, "R10 all pixels returned", 64'(exp_q.size()), 0);

    finish_run();
  end
endmodule